// File: doc/BRIEF.md
# Scanline Address Generator

This block works out, for every displayed scanline of a graphics frame, the byte address in video memory where that line's pixel data begins. It sits beside the CRT timing logic. A frame-start strobe restarts it. A line-start strobe asks it for the next line. The block turns raw CRT controller register fields into its working values: the start address, row pitch, split-screen row, last displayed line, scan repetition and address-substitution controls.

The rules that shape the address sequence are these. Each scanline belongs to a row. A row can be shown on several consecutive scanlines: two for double scan, and more in 256-colour mode through a repetition count. When a row ends, the line address moves forward by the row pitch, but a step mask can hold it back on selected rows. When the row counter reaches the split-screen row, the address falls back to zero. Before the address is presented, one or two of its upper bits can be replaced by low row bits, which gives the interleaved bank layouts of older display adapters.

All outputs are registered and change only on a line-start or frame-start strobe. Pixel fetch and serialisation are handled elsewhere.

Top module: `scanaddr_gen`

## Requirements
- R1: While `rst` is high, and until the first line-start strobe after reset, `line_addr_o` and `row_o` are 0 and `disp_end_o` is 0.
- R2: On the first line-start strobe after a frame-start strobe, `line_addr_o` becomes the start word `{start_hi, start_lo}` multiplied by 4, taken as a byte address, and `row_o` becomes 0. This holds when `step_sel` = 2'b11, so that no bit substitution applies.
- R3: When a row ends and the step mask passes, the base address for the next row is the current base plus `row_pitch` × 8 bytes, wrapping at the address width.
- R4: The step mask is `step_sel` XOR 2'b11. The base advances at the end of row r only when (r AND mask) equals mask. Otherwise it is unchanged.
- R5: When `dbl_scan` is 1, each row is shown on two consecutive scanlines.
- R6: When `wide_color` is 1, each row is shown on `rep_count`+1 scanlines, multiplied by two if `dbl_scan` is also 1. When `wide_color` is 0, `rep_count` has no effect.
- R7: The split row is `{split_b9, split_b8, split_lo}`. When the row that ends equals the split row, the next row's base is 0. This takes precedence over the step of R3.
- R8: The frame has `{vend_b9, vend_b8, vend_lo}` + 1 displayed lines. On any line-start strobe after the last displayed line, `disp_end_o` becomes 1 and `line_addr_o` and `row_o` keep their values.
- R9: When `step_sel[0]` is 0, the presented address has row bit 0 in bit 14 if `alt_hi` is 0, or in bit 15 if `alt_hi` is 1.
- R10: When `step_sel[1]` is 0, the presented address has row bit 1 in bit 15. This overrides R9 when both target bit 15.
- R11: A frame-start strobe clears `disp_end_o` and restarts the frame. A line-start strobe in the same cycle is ignored, so the next line-start strobe presents row 0 at the start address.
- R12: `row_o` reports the row of the line whose address is on `line_addr_o`. Between consecutive presented lines of one frame it stays the same or grows by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Restart strobe at the top of a frame |
| line_start | input | 1 | Request for the next scanline |
| start_hi | input | 8 | Start word, upper byte |
| start_lo | input | 8 | Start word, lower byte |
| row_pitch | input | 8 | Row pitch in units of 8 bytes |
| split_lo | input | 8 | Split row, bits 7:0 |
| split_b8 | input | 1 | Split row, bit 8 |
| split_b9 | input | 1 | Split row, bit 9 |
| vend_lo | input | 8 | Last displayed line, bits 7:0 |
| vend_b8 | input | 1 | Last displayed line, bit 8 |
| vend_b9 | input | 1 | Last displayed line, bit 9 |
| dbl_scan | input | 1 | Show each row on two scanlines |
| rep_count | input | 5 | Extra repetitions per row in 256-colour mode |
| wide_color | input | 1 | 256-colour shift mode enable |
| step_sel | input | 2 | Step mask and substitution control |
| alt_hi | input | 1 | Moves the row-bit-0 substitution from bit 14 to bit 15 |
| line_addr_o | output | ADDR_W | Byte address of the presented line |
| row_o | output | 10 | Row of the presented line |
| disp_end_o | output | 1 | Display area of the frame is exhausted |

## Verification
The assertions assume that the register fields stay constant from one frame-start strobe to the next, and that frame-start and line-start strobes are one cycle wide. The substitution checks compare against the control value sampled on the strobe cycle. The bench changes its configuration only while no strobe is active, and holds it for a whole frame. It pulses each strobe for exactly one cycle. The frame-start and line-start overlap of R11 is created deliberately, once, after a full frame.

// File: rtl/scanaddr_pkg.sv
package scanaddr_pkg;
  localparam int ROW_W = 10;
  localparam int REG_W = 8;
  localparam int REP_W = 5;

  typedef struct packed {
    logic [2*REG_W-1:0] start_word;
    logic [REG_W-1:0]   pitch;
    logic [ROW_W-1:0]   split_row;
    logic [ROW_W-1:0]   last_line;
    logic               dbl;
    logic [REP_W-1:0]   reps;
    logic [1:0]         adv_mask;
    logic               lo_en;
    logic               lo_alt;
    logic               hi_en;
  } scan_cfg_t;
endpackage

// File: rtl/scanaddr_cfg.sv
module scanaddr_cfg
  import scanaddr_pkg::*;
(
  input  logic [REG_W-1:0] start_hi,
  input  logic [REG_W-1:0] start_lo,
  input  logic [REG_W-1:0] row_pitch,
  input  logic [REG_W-1:0] split_lo,
  input  logic             split_b8,
  input  logic             split_b9,
  input  logic [REG_W-1:0] vend_lo,
  input  logic             vend_b8,
  input  logic             vend_b9,
  input  logic             dbl_scan,
  input  logic [REP_W-1:0] rep_count,
  input  logic             wide_color,
  input  logic [1:0]       step_sel,
  input  logic             alt_hi,
  output scan_cfg_t        cfg
);
  always_comb begin
    cfg.start_word = {start_hi, start_lo};
    cfg.pitch      = row_pitch;
    cfg.split_row  = {split_b9, split_b8, split_lo};
    cfg.last_line  = {vend_b9, vend_b8, vend_lo};
    cfg.dbl        = dbl_scan;
    cfg.reps       = wide_color ? rep_count : '0;
    cfg.adv_mask   = step_sel ^ 2'b11;
    cfg.lo_en      = ~step_sel[0];
    cfg.lo_alt     = alt_hi;
    cfg.hi_en      = ~step_sel[1];
  end
endmodule

// File: rtl/scanaddr_repeat.sv
module scanaddr_repeat #(
  parameter int REP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             scan,
  input  logic             dbl,
  input  logic [REP_W-1:0] reps,
  output logic             row_step
);
  logic             phase_q;
  logic [REP_W-1:0] cnt_q;
  logic             pair_done;

  assign pair_done = ~dbl | phase_q;
  assign row_step  = pair_done & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (restart) begin
      phase_q <= 1'b0;
      cnt_q   <= reps;
    end else if (scan) begin
      if (pair_done) begin
        phase_q <= 1'b0;
        cnt_q   <= (cnt_q == '0) ? reps : cnt_q - 1'b1;
      end else begin
        phase_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanaddr_subst.sv
module scanaddr_subst #(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        row_lsb,
  input  logic              lo_en,
  input  logic              lo_alt,
  input  logic              hi_en,
  output logic [ADDR_W-1:0] addr
);
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i == 14) begin : g_b14
      assign addr[i] = (lo_en & ~lo_alt) ? row_lsb[0] : base[i];
    end else if (i == 15) begin : g_b15
      assign addr[i] = hi_en ? row_lsb[1] :
                       (lo_en & lo_alt) ? row_lsb[0] : base[i];
    end else begin : g_pass
      assign addr[i] = base[i];
    end
  end
endmodule

// File: rtl/scanaddr_gen.sv
module scanaddr_gen
  import scanaddr_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PITCH_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 line_start,
  input  logic [7:0]           start_hi,
  input  logic [7:0]           start_lo,
  input  logic [7:0]           row_pitch,
  input  logic [7:0]           split_lo,
  input  logic                 split_b8,
  input  logic                 split_b9,
  input  logic [7:0]           vend_lo,
  input  logic                 vend_b8,
  input  logic                 vend_b9,
  input  logic                 dbl_scan,
  input  logic [4:0]           rep_count,
  input  logic                 wide_color,
  input  logic [1:0]           step_sel,
  input  logic                 alt_hi,
  output logic [ADDR_W-1:0]    line_addr_o,
  output logic [9:0]           row_o,
  output logic                 disp_end_o
);
  localparam int SCAN_W = ROW_W + 1;

  scan_cfg_t         cfg;
  logic [ROW_W-1:0]  row_q;
  logic [SCAN_W-1:0] scan_q;
  logic [SCAN_W-1:0] height;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_load;
  logic [ADDR_W-1:0] pitch_bytes;
  logic [ADDR_W-1:0] shown_addr;
  logic              active;
  logic              take_line;
  logic              row_step;
  logic              step_ok;

  scanaddr_cfg u_cfg (
    .start_hi(start_hi), .start_lo(start_lo), .row_pitch(row_pitch),
    .split_lo(split_lo), .split_b8(split_b8), .split_b9(split_b9),
    .vend_lo(vend_lo), .vend_b8(vend_b8), .vend_b9(vend_b9),
    .dbl_scan(dbl_scan), .rep_count(rep_count), .wide_color(wide_color),
    .step_sel(step_sel), .alt_hi(alt_hi), .cfg(cfg)
  );

  assign height      = {1'b0, cfg.last_line} + 1'b1;
  assign active      = scan_q < height;
  assign take_line   = line_start & ~frame_start;
  assign base_load   = ADDR_W'({cfg.start_word, 2'b00});
  assign pitch_bytes = ADDR_W'(cfg.pitch) << PITCH_SHIFT;
  assign step_ok     = (row_q[1:0] & cfg.adv_mask) == cfg.adv_mask;

  scanaddr_repeat #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst(rst), .restart(frame_start),
    .scan(take_line & active), .dbl(cfg.dbl), .reps(cfg.reps),
    .row_step(row_step)
  );

  scanaddr_subst #(.ADDR_W(ADDR_W)) u_sub (
    .base(base_q), .row_lsb(row_q[1:0]), .lo_en(cfg.lo_en),
    .lo_alt(cfg.lo_alt), .hi_en(cfg.hi_en), .addr(shown_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q       <= '0;
      scan_q      <= '0;
      base_q      <= '0;
      line_addr_o <= '0;
      row_o       <= '0;
      disp_end_o  <= 1'b0;
    end else if (frame_start) begin
      row_q      <= '0;
      scan_q     <= '0;
      base_q     <= base_load;
      disp_end_o <= 1'b0;
    end else if (take_line) begin
      if (active) begin
        line_addr_o <= shown_addr;
        row_o       <= row_q;
        disp_end_o  <= 1'b0;
        scan_q      <= scan_q + 1'b1;
        if (row_step) begin
          row_q <= row_q + 1'b1;
          if (row_q == cfg.split_row)
            base_q <= '0;
          else if (step_ok)
            base_q <= base_q + pitch_bytes;
        end
      end else begin
        disp_end_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanaddr_gen_chk.sv
module scanaddr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              line_start,
  input logic [1:0]        step_sel,
  input logic              alt_hi,
  input logic [ADDR_W-1:0] line_addr_o,
  input logic [9:0]        row_o,
  input logic              disp_end_o
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (line_addr_o == '0 && row_o == '0 && !disp_end_o));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!line_start && !frame_start) |=>
      ($stable(line_addr_o) && $stable(row_o) && $stable(disp_end_o)));

  p_end_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (disp_end_o && line_start && !frame_start) |=>
      (disp_end_o && $stable(line_addr_o) && $stable(row_o)));

  p_frame_clear_r11: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!disp_end_o && $stable(line_addr_o)));

  p_row_mono_r12: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start) |=>
      (row_o == $past(row_o) || row_o == $past(row_o) + 1'b1 || row_o == '0));

  p_sub_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start && step_sel == 2'b10 && !alt_hi) |=>
      (disp_end_o || line_addr_o[14] == row_o[0]));

  p_sub_hi_r10: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start && !step_sel[1]) |=>
      (disp_end_o || line_addr_o[15] == row_o[1]));
endmodule

bind scanaddr_gen scanaddr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
  .step_sel(step_sel), .alt_hi(alt_hi), .line_addr_o(line_addr_o),
  .row_o(row_o), .disp_end_o(disp_end_o)
);

// File: tb/tb_scanaddr_gen.sv
module tb_scanaddr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, line_start = 1'b0;
  logic [7:0] start_hi = 8'h12, start_lo = 8'h34, row_pitch = 8'h50;
  logic [7:0] split_lo = 8'd5, vend_lo = 8'd23;
  logic split_b8 = 1'b0, split_b9 = 1'b0, vend_b8 = 1'b0, vend_b9 = 1'b0;
  logic dbl_scan = 1'b0, wide_color = 1'b0, alt_hi = 1'b0;
  logic [4:0] rep_count = 5'd2;
  logic [1:0] step_sel = 2'b11;
  logic [AW-1:0] line_addr_o;
  logic [9:0] row_o;
  logic disp_end_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanaddr_gen dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .start_hi(start_hi), .start_lo(start_lo), .row_pitch(row_pitch),
    .split_lo(split_lo), .split_b8(split_b8), .split_b9(split_b9),
    .vend_lo(vend_lo), .vend_b8(vend_b8), .vend_b9(vend_b9),
    .dbl_scan(dbl_scan), .rep_count(rep_count), .wide_color(wide_color),
    .step_sel(step_sel), .alt_hi(alt_hi),
    .line_addr_o(line_addr_o), .row_o(row_o), .disp_end_o(disp_end_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int scans_per_row();
    return (dbl_scan ? 2 : 1) * ((wide_color ? int'(rep_count) : 0) + 1);
  endfunction

  function automatic int exp_row(input int y);
    return y / scans_per_row();
  endfunction

  function automatic int exp_addr(input int y);
    int row, base, cmp, msk, b;
    row  = exp_row(y);
    base = ({16'h0, start_hi, start_lo}) * 4;
    cmp  = {split_b9, split_b8, split_lo};
    msk  = (~int'(step_sel)) & 3;
    for (int r = 0; r < row; r++) begin
      if (r == cmp) base = 0;
      else if ((r & msk) == msk) base = (base + int'(row_pitch) * 8) % (1 << AW);
    end
    if (!step_sel[0]) begin
      b = alt_hi ? 15 : 14;
      base = (base & ~(1 << b)) | ((row & 1) << b);
    end
    if (!step_sel[1]) base = (base & ~(1 << 15)) | (((row >> 1) & 1) << 15);
    return base;
  endfunction

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
  endtask

  // Runs one frame and checks every line plus one line past the end
  task automatic run_frame(input string req);
    int h, last_a, last_r;
    h = {vend_b9, vend_b8, vend_lo} + 1;
    pulse_frame();
    check("R11 frame clears end flag", int'(disp_end_o), 0);
    for (int y = 0; y < h; y++) begin
      pulse_line();
      check(req, int'(line_addr_o), exp_addr(y));
      check("R12 row", int'(row_o), exp_row(y));
    end
    last_a = exp_addr(h - 1);
    last_r = exp_row(h - 1);
    pulse_line();
    check("R8 end flag", int'(disp_end_o), 1);
    check("R8 address held", int'(line_addr_o), last_a);
    check("R8 row held", int'(row_o), last_r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset addr", int'(line_addr_o), 0);
    check("R1 reset row", int'(row_o), 0);
    check("R1 reset end", int'(disp_end_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", int'(line_addr_o), 0);

    // R2 first line at start address, R3 pitch step, R7 split at row 5
    run_frame("R2 R3 R7 base frame");
    pulse_frame();
    pulse_line();
    check("R2 first line", int'(line_addr_o), 32'h48D0);

    // Sweep masks, substitution, double scan, repetition, split row
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 2; a++)
        for (int d = 0; d < 2; d++)
          for (int w = 0; w < 2; w++)
            for (int c = 0; c < 2; c++) begin
              step_sel   = 2'(s);
              alt_hi     = a[0];
              dbl_scan   = d[0];
              wide_color = w[0];
              split_lo   = c[0] ? 8'd88 : 8'd5;
              split_b9   = c[0];
              run_frame("R4 R5 R6 R7 R9 R10 sweep");
            end

    // R6 repetition ignored without 256-colour mode
    step_sel = 2'b11; alt_hi = 1'b0; dbl_scan = 1'b0; wide_color = 1'b0;
    rep_count = 5'd7; split_lo = 8'd200; split_b9 = 1'b0;
    run_frame("R6 rep_count ignored");
    wide_color = 1'b1; rep_count = 5'd3;
    run_frame("R6 four scans per row");

    // R8 tall frame via bit 8, split row at 200
    wide_color = 1'b0; vend_lo = 8'd0; vend_b8 = 1'b1;
    run_frame("R7 R8 height bit 8");
    // R8 height bit 9, R7 split bit 8 (row 300)
    vend_b8 = 1'b0; vend_b9 = 1'b1; split_lo = 8'd44; split_b8 = 1'b1;
    run_frame("R7 R8 height bit 9");

    // R11 frame start and line start together
    vend_b9 = 1'b0; vend_lo = 8'd9; split_b8 = 1'b0;
    pulse_frame();
    for (int y = 0; y < 4; y++) pulse_line();
    @(negedge clk) begin frame_start = 1'b1; line_start = 1'b1; end
    @(negedge clk) begin frame_start = 1'b0; line_start = 1'b0; end
    check("R11 overlap row held", int'(row_o), 3);
    pulse_line();
    check("R11 restart row", int'(row_o), 0);
    check("R11 restart addr", int'(line_addr_o), 32'h48D0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule